// File: doc/BRIEF.md
# Rectangle Fill and Vertical Scroll Engine

This block is a small 2D drawing engine for a 32-bit-per-pixel frame buffer. Software loads a command through a register-write port: an operation code, a raster code, a colour, an origin, a size and (for scrolls) a destination. Writing the width register launches the command. The engine then walks the rectangle row by row, left to right, issuing one pixel access per cycle on a simple memory port whose read data returns one cycle after the request.

Two operations are supported. A fill combines every pixel of the rectangle with the foreground colour under the selected raster code. A vertical scroll copies a block to a destination with the same column and a different row, picking the row order so that an overlapping copy never reads a row it has already overwritten. A busy level covers the pixel walk and a one-cycle done pulse marks the end of every launched command, including those that draw nothing.

Top module: `rect_blit_engine`

## Requirements
- R1: Register writes (address on `reg_addr`: 0 opcode, 1 raster code, 2 colour, 3 base Y, 4 base X, 5 destination Y, 6 destination X, 7 height, 8 width) update the command; the width write launches it; any write while `busy` is high or in the cycle after a launching write is ignored.
- R2: Opcode 0x08 is a fill and 0x0B a scroll; any other opcode makes no memory access, keeps `busy` low and gives `done` in the second cycle after the width write.
- R3: The byte address of pixel (y, x) is y*8192 + x*4; pixels are visited row by row, left to right within a row.
- R4: A fill with raster code 0x83 writes the 32-bit colour register unchanged (blue in bits 23:16, green 15:8, red 7:0) to each pixel, one write per cycle.
- R5: A fill with raster code 0x86 reads each pixel and writes colour XOR old value to the same address in the next cycle.
- R6: A fill with raster code 0x85 (keep old), or with any code other than 0x83 and 0x86, makes no memory access and completes like a rejected command.
- R7: A scroll reads each source pixel and writes the returned value unchanged to the destination pixel in the next cycle, whatever the raster code.
- R8: A scroll is carried out only when base X equals destination X and base Y differs from destination Y; otherwise it is rejected as in R2.
- R9: A scroll with destination Y greater than base Y copies rows from the last row up to the first; otherwise from the first row down.
- R10: A width or height of zero completes with no memory access, `busy` low and `done` in the second cycle after the width write.
- R11: `busy` rises in the second cycle after the width write, stays high through every access and falls together with a one-cycle `done` pulse in the cycle after the last write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Pixel access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Pixel byte address |
| mem_wdata | output | 32 | Pixel write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted row or column counter shows at once on `mem_addr`, since every busy cycle is an access and the bench compares each one against its own ordered list. A wrong direction choice for an overlapping scroll surfaces as a read address from the wrong row in the first busy cycle and as a damaged destination block after completion. A stuck state machine shows as `busy` or `done` off the expected cycle, which is fixed by the access count alone.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int RA_BITS = 4;

  localparam logic [7:0] OP_FILL   = 8'h08;
  localparam logic [7:0] OP_SCROLL = 8'h0B;
  localparam logic [7:0] ROP_NEW   = 8'h83;
  localparam logic [7:0] ROP_KEEP  = 8'h85;
  localparam logic [7:0] ROP_XOR   = 8'h86;

  localparam logic [RA_BITS-1:0] RA_OP     = 4'd0;
  localparam logic [RA_BITS-1:0] RA_ROP    = 4'd1;
  localparam logic [RA_BITS-1:0] RA_COLOUR = 4'd2;
  localparam logic [RA_BITS-1:0] RA_BY     = 4'd3;
  localparam logic [RA_BITS-1:0] RA_BX     = 4'd4;
  localparam logic [RA_BITS-1:0] RA_DY     = 4'd5;
  localparam logic [RA_BITS-1:0] RA_DX     = 4'd6;
  localparam logic [RA_BITS-1:0] RA_H      = 4'd7;
  localparam logic [RA_BITS-1:0] RA_W      = 4'd8;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} walk_state_e;

  // Byte address of a pixel for a given pitch and pixel size.
  function automatic logic [63:0] pix_addr(input logic [63:0] y, input logic [63:0] x,
                                           input logic [63:0] pitch, input logic [63:0] psize);
    return y * pitch + x * psize;
  endfunction

  // True when the raster code needs the old pixel value.
  function automatic logic rop_reads_old(input logic [7:0] rop);
    return rop == ROP_XOR;
  endfunction

  // True when a fill with this raster code writes anything.
  function automatic logic rop_draws(input logic [7:0] rop);
    return (rop == ROP_NEW) || (rop == ROP_XOR);
  endfunction
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RA_BITS-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               lock,
  output logic [7:0]         opcode,
  output logic [7:0]         rop,
  output logic [DATA_W-1:0]  colour,
  output logic [COORD_W-1:0] base_y,
  output logic [COORD_W-1:0] base_x,
  output logic [COORD_W-1:0] dst_y,
  output logic [COORD_W-1:0] dst_x,
  output logic [COORD_W-1:0] height,
  output logic [COORD_W-1:0] width,
  output logic               start
);
  logic accept;
  assign accept = wr_en && !lock && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opcode <= '0;
      rop    <= ROP_NEW;
      colour <= '0;
      base_y <= '0;
      base_x <= '0;
      dst_y  <= '0;
      dst_x  <= '0;
      height <= '0;
      width  <= '0;
      start  <= 1'b0;
    end else begin
      start <= accept && (addr == RA_W);
      if (accept) begin
        case (addr)
          RA_OP:     opcode <= wdata[7:0];
          RA_ROP:    rop    <= wdata[7:0];
          RA_COLOUR: colour <= wdata;
          RA_BY:     base_y <= wdata[COORD_W-1:0];
          RA_BX:     base_x <= wdata[COORD_W-1:0];
          RA_DY:     dst_y  <= wdata[COORD_W-1:0];
          RA_DX:     dst_x  <= wdata[COORD_W-1:0];
          RA_H:      height <= wdata[COORD_W-1:0];
          RA_W:      width  <= wdata[COORD_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  // R1
  locked_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(colour));
  // R1
  locked_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(width) && !start));
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int COORD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               bottom_up,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  output logic [COORD_W-1:0] col,
  output logic [COORD_W-1:0] row,
  output logic               last
);
  localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

  logic [COORD_W-1:0] c_q, r_q;
  logic               row_end;

  assign row_end = (c_q == width - ONE);
  assign last    = row_end && (r_q == height - ONE);
  assign col     = c_q;
  assign row     = bottom_up ? (height - ONE - r_q) : r_q;

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      c_q <= '0;
      r_q <= '0;
    end else if (step) begin
      if (row_end) begin
        c_q <= '0;
        r_q <= r_q + ONE;
      end else begin
        c_q <= c_q + ONE;
      end
    end
  end

  // R3
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (c_q < width) && (r_q < height));
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import blit_pkg::*;
#(
  parameter int COORD_W    = 16,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 8192,
  parameter int PIX_BYTES  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [RA_BITS-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               busy,
  output logic               done
);
  localparam logic [63:0] PITCH = 64'(LINE_BYTES);
  localparam logic [63:0] PSIZE = 64'(PIX_BYTES);

  logic [7:0]         opcode, rop;
  logic [DATA_W-1:0]  colour;
  logic [COORD_W-1:0] base_y, base_x, dst_y, dst_x, height, width;
  logic               start;

  blit_regs #(.COORD_W(COORD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .lock(busy), .opcode(opcode), .rop(rop), .colour(colour),
    .base_y(base_y), .base_x(base_x), .dst_y(dst_y), .dst_x(dst_x),
    .height(height), .width(width), .start(start)
  );

  // Command decode, visible to the assertions.
  logic is_fill, is_scroll, has_area, needs_read, bottom_up;
  logic cmd_go, cmd_reject, pix_step, pix_last;

  assign is_fill    = (opcode == OP_FILL) && rop_draws(rop);
  assign is_scroll  = (opcode == OP_SCROLL) && (base_x == dst_x) && (base_y != dst_y);
  assign has_area   = (width != '0) && (height != '0);
  assign needs_read = is_scroll || rop_reads_old(rop);
  assign bottom_up  = is_scroll && (dst_y > base_y);
  assign cmd_go     = start && has_area && (is_fill || is_scroll);
  assign cmd_reject = start && !cmd_go;

  walk_state_e st_q;
  assign busy     = (st_q != ST_IDLE);
  assign pix_step = (st_q == ST_WRITE);

  logic [COORD_W-1:0] col, row;

  blit_walker #(.COORD_W(COORD_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(start), .step(pix_step), .bottom_up(bottom_up),
    .width(width), .height(height), .col(col), .row(row), .last(pix_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_go) st_q <= needs_read ? ST_READ : ST_WRITE;
          done <= cmd_reject;
        end
        ST_READ: st_q <= ST_WRITE;
        ST_WRITE: begin
          if (pix_last) begin
            st_q <= ST_IDLE;
            done <= 1'b1;
          end else begin
            st_q <= needs_read ? ST_READ : ST_WRITE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Pixel addressing.
  logic [COORD_W-1:0] src_y, src_x, tgt_y, tgt_x;
  logic [ADDR_W-1:0]  src_addr, tgt_addr;

  assign src_y    = base_y + row;
  assign src_x    = base_x + col;
  assign tgt_y    = dst_y + row;
  assign tgt_x    = dst_x + col;
  assign src_addr = ADDR_W'(pix_addr(64'(src_y), 64'(src_x), PITCH, PSIZE));
  assign tgt_addr = ADDR_W'(pix_addr(64'(tgt_y), 64'(tgt_x), PITCH, PSIZE));

  assign mem_req   = busy;
  assign mem_we    = pix_step;
  assign mem_addr  = (pix_step && is_scroll) ? tgt_addr : src_addr;
  assign mem_wdata = is_scroll          ? mem_rdata :
                     rop_reads_old(rop) ? (colour ^ mem_rdata) : colour;

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R11
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R5
  rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (mem_req && mem_we));
  // R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> (!busy && done));
  // R10
  zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !has_area) |=> (!mem_req && done));
endmodule

// File: tb/tb_rect_blit_engine.sv
module tb_rect_blit_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we, busy, done;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rect_blit_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );

  // Frame buffer model: unwritten words hold a pattern derived from the address.
  logic [31:0] fb [int unsigned];
  logic [31:0] sh [int unsigned];

  function automatic logic [31:0] seed(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0F0F1234;
  endfunction

  function automatic logic [31:0] fb_rd(input logic [31:0] a);
    return fb.exists(a) ? fb[a] : seed(a);
  endfunction

  function automatic logic [31:0] sh_rd(input logic [31:0] a);
    return sh.exists(a) ? sh[a] : seed(a);
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) fb[mem_addr] = mem_wdata;
      else        mem_rdata <= fb_rd(mem_addr);
    end
  end

  // Expected access list.
  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
  } acc_t;
  acc_t expq[$];

  function automatic logic [31:0] paddr(input int y, input int x);
    int unsigned lin;
    lin = 32'(y) * 32'd8192;
    return lin + 32'(x) * 32'd4;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit we, input logic [31:0] a, input logic [31:0] d);
    acc_t e;
    e.we = we; e.addr = a; e.data = d;
    expq.push_back(e);
  endtask

  task automatic build(input int op, input int rop, input logic [31:0] fg,
                       input int by, input int bx, input int dy, input int dx,
                       input int h, input int w);
    logic [31:0] a, s, v;
    sh = fb;
    expq.delete();
    if (w == 0 || h == 0) return;
    if (op == 8'h08) begin
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++) begin
          a = paddr(by + r, bx + c);
          if (rop == 8'h83) begin
            push(1'b1, a, fg); sh[a] = fg;
          end else if (rop == 8'h86) begin
            v = sh_rd(a) ^ fg;
            push(1'b0, a, '0); push(1'b1, a, v); sh[a] = v;
          end
        end
    end else if (op == 8'h0B && bx == dx && by != dy) begin
      for (int k = 0; k < h; k++) begin
        int r;
        r = (dy > by) ? (h - 1 - k) : k;
        for (int c = 0; c < w; c++) begin
          s = paddr(by + r, bx + c);
          a = paddr(dy + r, dx + c);
          v = sh_rd(s);
          push(1'b0, s, '0); push(1'b1, a, v); sh[a] = v;
        end
      end
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic run(input string req, input int op, input int rop, input logic [31:0] fg,
                     input int by, input int bx, input int dy, input int dx,
                     input int h, input int w, input bit poke);
    int n, done_at, idx;
    acc_t e;
    wr_reg(4'd0, 32'(op));
    wr_reg(4'd1, 32'(rop));
    wr_reg(4'd2, fg);
    wr_reg(4'd3, 32'(by));
    wr_reg(4'd4, 32'(bx));
    wr_reg(4'd5, 32'(dy));
    wr_reg(4'd6, 32'(dx));
    wr_reg(4'd7, 32'(h));
    build(op, rop, fg, by, bx, dy, dx, h, w);
    n = expq.size();
    wr_reg(4'd8, 32'(w));
    done_at = -1;
    idx = 0;
    while (idx < n + 10 && done_at < 0) begin
      bit exp_busy;
      exp_busy = (n > 0) && idx >= 1 && idx <= n;
      chk(busy == exp_busy, req, $sformatf("busy at cycle %0d", idx), 32'(busy), 32'(exp_busy));
      chk(mem_req == exp_busy, req, $sformatf("mem_req at cycle %0d", idx), 32'(mem_req), 32'(exp_busy));
      if (mem_req && expq.size() > 0) begin
        e = expq.pop_front();
        chk(mem_we == e.we, req, "access kind", 32'(mem_we), 32'(e.we));
        chk(mem_addr == e.addr, req, "access address", mem_addr, e.addr);
        if (e.we) chk(mem_wdata == e.data, req, "write data", mem_wdata, e.data);
      end
      if (done) done_at = idx;
      if (poke && idx == 2) begin
        reg_wr_en = 1'b1; reg_addr = 4'd2; reg_wdata = ~fg;
      end else if (poke && idx == 3) begin
        reg_addr = 4'd8; reg_wdata = 32'd5;
      end else if (poke && idx == 4) begin
        reg_wr_en = 1'b0;
      end
      @(negedge clk);
      idx++;
    end
    reg_wr_en = 1'b0;
    chk(done_at == ((n > 0) ? n + 1 : 1), req, "done cycle", 32'(done_at), 32'((n > 0) ? n + 1 : 1));
    chk(expq.size() == 0, req, "accesses left", 32'(expq.size()), 32'd0);
    for (int k = 0; k < 3; k++) begin
      chk(!busy && !done && !mem_req, req, "quiet after done",
          {29'd0, busy, done, mem_req}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=%0h expected=%0h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_req, "R11", "reset state", {29'd0, busy, done, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R3: plain fill, colour with distinct blue/green/red bytes
    run("R4", 8'h08, 8'h83, 32'h0033_2211, 5, 7, 0, 0, 3, 4, 0);
    // R3: far coordinates in the buffer
    run("R3", 8'h08, 8'h83, 32'h00AB_CDEF, 1000, 2046, 0, 0, 1, 2, 0);
    // R5: XOR fill with read-modify-write
    run("R5", 8'h08, 8'h86, 32'h00FF_00FF, 5, 7, 0, 0, 2, 3, 0);
    // R6: keep-old and unknown raster codes draw nothing
    run("R6", 8'h08, 8'h85, 32'h1234_5678, 3, 3, 0, 0, 2, 2, 0);
    run("R6", 8'h08, 8'h42, 32'h1234_5678, 3, 3, 0, 0, 2, 2, 0);
    // R2: unknown opcode
    run("R2", 8'h05, 8'h83, 32'h0000_00FF, 3, 3, 0, 0, 2, 2, 0);
    // R7 R9: top-down scroll, raster code set to XOR has no effect
    run("R7", 8'h0B, 8'h86, 32'hFFFF_FFFF, 10, 2, 8, 2, 4, 3, 0);
    // R9: bottom-up overlapping scroll
    run("R9", 8'h0B, 8'h85, 32'h0, 20, 4, 22, 4, 4, 2, 0);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 2; c++)
        chk(fb_rd(paddr(22 + r, 4 + c)) == sh_rd(paddr(22 + r, 4 + c)), "R9",
            "scrolled block", fb_rd(paddr(22 + r, 4 + c)), sh_rd(paddr(22 + r, 4 + c)));
    // R8: rejected scrolls
    run("R8", 8'h0B, 8'h83, 32'h0, 10, 2, 12, 3, 2, 2, 0);
    run("R8", 8'h0B, 8'h83, 32'h0, 10, 2, 10, 2, 2, 2, 0);
    // R10: zero sizes
    run("R10", 8'h08, 8'h83, 32'h0000_0011, 1, 1, 0, 0, 3, 0, 0);
    run("R10", 8'h08, 8'h83, 32'h0000_0011, 1, 1, 0, 0, 0, 3, 0);
    // R1: colour and width writes during busy are ignored
    run("R1", 8'h08, 8'h83, 32'h0055_6677, 40, 40, 0, 0, 2, 4, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule